// File: doc/BRIEF.md
# Power-of-Two Buddy Block Allocator

This block hands out and takes back pieces of a fixed region of 2^N minimum-size units. Every piece is a power of two in size and sits on an address that is a multiple of its own size. An allocation request carries a size in units. The block rounds the size up to the next power of two. It takes the lowest-addressed hole of the smallest large-enough order and halves that hole until the piece fits. The leftover upper halves go back into the free pool.

A release request carries a block address and its order. The block checks that exactly that block is live. It then combines the block with its equal-sized partner (address XOR block size) for as long as the partner is free, climbing one order at a time. The block has no backing data memory. It only tracks which blocks are free and which are granted.

Free state is held as one bit per block per order, in one bitmap bank for each order. The search steps upward one order per clock, and each split or merge step takes one clock. The caller presents a request while `busy` is low. Exactly one response pulse comes back, carrying a grant, a refusal or an error.

Top module: `buddy_alloc`

## Requirements
- R1: After reset the whole region is one free block of order N at address 0; `busy` and `rsp_valid` are low.
- R2: An allocation of size s (1 ≤ s ≤ 2^N) is granted order k, the smallest k with 2^k ≥ s, reported on `rsp_order`; for example 70 units gets order 7 and 35 units gets order 6.
- R3: The grant comes from the smallest order at or above k that holds a free block, and within that order from the free block with the lowest address.
- R4: When the hole found is larger than needed, it is halved repeatedly; the lower half is kept each time and every upper half becomes free at its order. In a 2^10 region, granting 70, 35 and 80 in turn leaves free holes of 64 units at 192, 128 units at 384 and 512 units at 512.
- R5: A valid release of the block at address a, order k, makes it free and merges it with the block at a XOR 2^k while that block is free at the same order, repeating one order up each time; the response reports the final merged address and order with both flags low.
- R6: An allocation with size 0, size above 2^N, or no free block at or above the needed order answers with `rsp_fail` high, and leaves every free and granted block unchanged.
- R7: A release whose order exceeds N, whose address is not a multiple of 2^order, or which names a block not currently granted at that order answers with `rsp_err` high and changes nothing.
- R8: A request is taken only on a clock edge where `req_valid` is high and `busy` is low; `req_valid` while `busy` is high is ignored. Each accepted request gives one single-cycle `rsp_valid`, and `busy` is low in that cycle.
- R9: Counting clock edges after the accepting edge, the response is visible after 2(f−k)+1 edges for a grant found at order f; after N−k+1 edges for a refusal by search; after m+1 edges for a release that merges m times; and after 0 edges (in the very next cycle) for a bad size or a bad release.
- R10: `rsp_fail` and `rsp_err` are never both high, and a successful response always has `rsp_addr` aligned to 2^`rsp_order`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_free | input | 1 | 0 = allocate, 1 = release |
| req_size | input | N+1 | Allocation size in units |
| req_addr | input | N | Release: block address in units |
| req_order | input | clog2(N+1) | Release: block order |
| busy | output | 1 | Request in progress; new requests ignored |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fail | output | 1 | Allocation refused |
| rsp_err | output | 1 | Release rejected |
| rsp_addr | output | N | Granted or merged block address |
| rsp_order | output | clog2(N+1) | Granted or merged block order |

## Verification
The assertions take for granted that the free and granted bitmaps start from the reset image and change only through the state machine's write ports. They also take for granted that nothing but a just-accepted request steers the search, split and merge steps. Request fields are read only in the accepting cycle, so the stimulus freely drives stray release requests while `busy` is high to show they are dropped. Out-of-range sizes, orders above N, misaligned addresses and double releases are driven on purpose, each followed by a check that the pool has not moved.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_SPLIT,
    ST_MERGE
  } bstate_e;
endpackage

// File: rtl/buddy_rst_sync.sv
module buddy_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/buddy_order_bank.sv
// Free and granted bitmaps for the blocks of one order K.
module buddy_order_bank #(
  parameter int N = 10,
  parameter int K = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] q_addr,
  input  logic         free_we,
  input  logic         free_val,
  input  logic [N-1:0] free_addr,
  input  logic         alloc_we,
  input  logic         alloc_val,
  input  logic [N-1:0] alloc_addr,
  output logic         any_free,
  output logic [N-1:0] first_addr,
  output logic         q_free,
  output logic         q_alloc
);
  localparam int W  = 1 << (N - K);
  localparam int IW = (N - K > 0) ? (N - K) : 1;

  logic [W-1:0]  free_q, free_d, alloc_q, alloc_d;
  logic [IW-1:0] fw_idx, aw_idx, q_idx, first_idx;

  assign fw_idx = IW'(free_addr >> K);
  assign aw_idx = IW'(alloc_addr >> K);
  assign q_idx  = IW'(q_addr >> K);

  always_comb begin
    free_d  = free_q;
    alloc_d = alloc_q;
    if (free_we)  free_d[fw_idx]  = free_val;
    if (alloc_we) alloc_d[aw_idx] = alloc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q  <= (K == N) ? W'(1) : '0;
      alloc_q <= '0;
    end else begin
      if (free_we)  free_q  <= free_d;
      if (alloc_we) alloc_q <= alloc_d;
    end
  end

  // lowest-index free block wins
  always_comb begin
    first_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (free_q[i]) first_idx = IW'(i);
    end
  end

  assign any_free   = |free_q;
  assign first_addr = N'(first_idx) << K;
  assign q_free     = free_q[q_idx];
  assign q_alloc    = alloc_q[q_idx];

  // a block is never added twice to the free pool
  assert_free_insert_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_we && free_val) |-> !free_q[fw_idx]);
  // a block is taken from the pool only when it is in it
  assert_free_take_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (free_we && !free_val) |-> free_q[fw_idx]);
  // a granted mark is never set on a block already granted
  assert_grant_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_we && alloc_val) |-> !alloc_q[aw_idx]);
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc #(
  parameter  int N  = 10,
  localparam int OW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_free,
  input  logic [N:0]    req_size,
  input  logic [N-1:0]  req_addr,
  input  logic [OW-1:0] req_order,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_fail,
  output logic          rsp_err,
  output logic [N-1:0]  rsp_addr,
  output logic [OW-1:0] rsp_order
);
  import buddy_pkg::*;

  localparam int            NS  = 1 << OW;
  localparam logic [OW-1:0] TOP = OW'(N);

  logic rst_n_s;
  buddy_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  bstate_e       state_q, state_d;
  logic [OW-1:0] cur_q, cur_d, want_q, want_d;
  logic [N-1:0]  base_q, base_d;
  logic          rv_q, rv_d, rf_q, rf_d, re_q, re_d;
  logic [N-1:0]  ra_q, ra_d;
  logic [OW-1:0] ro_q, ro_d;

  logic [NS-1:0] any_free_v, q_free_v, q_alloc_v;
  logic [N-1:0]  first_addr_a [NS];
  logic          free_we, free_val, alloc_we, alloc_val;
  logic [OW-1:0] free_ord, alloc_ord;
  logic [N-1:0]  free_addr, alloc_addr, q_addr, bud_bit;

  // size to order and request checks
  logic          size_ok, free_ok, align_ok;
  logic [OW-1:0] size_ord;

  always_comb begin
    size_ord = TOP;
    for (int k = N; k >= 0; k--) begin
      if (req_size <= ((N+1)'(1) << k)) size_ord = OW'(k);
    end
    size_ok  = (req_size != '0) && (req_size <= ((N+1)'(1) << N));
    align_ok = (req_addr & ((N'(1) << req_order) - N'(1))) == '0;
    free_ok  = (req_order <= TOP) && align_ok && q_alloc_v[req_order];
  end

  assign bud_bit = N'(1) << cur_q;
  assign q_addr  = (state_q == ST_MERGE) ? (base_q ^ bud_bit) : req_addr;

  for (genvar k = 0; k < NS; k++) begin : g_ord
    if (k <= N) begin : g_bank
      buddy_order_bank #(.N(N), .K(k)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n_s),
        .q_addr    (q_addr),
        .free_we   (free_we && (free_ord == OW'(k))),
        .free_val  (free_val),
        .free_addr (free_addr),
        .alloc_we  (alloc_we && (alloc_ord == OW'(k))),
        .alloc_val (alloc_val),
        .alloc_addr(alloc_addr),
        .any_free  (any_free_v[k]),
        .first_addr(first_addr_a[k]),
        .q_free    (q_free_v[k]),
        .q_alloc   (q_alloc_v[k])
      );
    end else begin : g_pad
      assign any_free_v[k]   = 1'b0;
      assign q_free_v[k]     = 1'b0;
      assign q_alloc_v[k]    = 1'b0;
      assign first_addr_a[k] = '0;
    end
  end

  always_comb begin
    state_d = state_q;  cur_d = cur_q;  want_d = want_q;  base_d = base_q;
    rv_d = 1'b0;  rf_d = 1'b0;  re_d = 1'b0;  ra_d = '0;  ro_d = '0;
    free_we  = 1'b0;  free_val  = 1'b0;  free_ord  = cur_q;  free_addr  = base_q;
    alloc_we = 1'b0;  alloc_val = 1'b0;  alloc_ord = cur_q;  alloc_addr = base_q;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        if (!req_free) begin
          if (size_ok) begin
            want_d = size_ord;  cur_d = size_ord;  state_d = ST_SEARCH;
          end else begin
            rv_d = 1'b1;  rf_d = 1'b1;
          end
        end else if (free_ok) begin
          alloc_we = 1'b1;  alloc_ord = req_order;  alloc_addr = req_addr;
          base_d = req_addr;  cur_d = req_order;  state_d = ST_MERGE;
        end else begin
          rv_d = 1'b1;  re_d = 1'b1;
        end
      end
      ST_SEARCH: begin
        if (any_free_v[cur_q]) begin
          free_we = 1'b1;  free_addr = first_addr_a[cur_q];
          if (cur_q == want_q) begin
            alloc_we = 1'b1;  alloc_val = 1'b1;  alloc_addr = first_addr_a[cur_q];
            rv_d = 1'b1;  ra_d = first_addr_a[cur_q];  ro_d = cur_q;  state_d = ST_IDLE;
          end else begin
            base_d = first_addr_a[cur_q];  cur_d = cur_q - OW'(1);  state_d = ST_SPLIT;
          end
        end else if (cur_q == TOP) begin
          rv_d = 1'b1;  rf_d = 1'b1;  state_d = ST_IDLE;
        end else begin
          cur_d = cur_q + OW'(1);
        end
      end
      ST_SPLIT: begin
        free_we = 1'b1;  free_val = 1'b1;  free_addr = base_q | bud_bit;
        if (cur_q == want_q) begin
          alloc_we = 1'b1;  alloc_val = 1'b1;
          rv_d = 1'b1;  ra_d = base_q;  ro_d = cur_q;  state_d = ST_IDLE;
        end else begin
          cur_d = cur_q - OW'(1);
        end
      end
      default: begin  // ST_MERGE
        free_we = 1'b1;
        if (cur_q != TOP && q_free_v[cur_q]) begin
          free_addr = q_addr;
          base_d = base_q & ~bud_bit;  cur_d = cur_q + OW'(1);
        end else begin
          free_val = 1'b1;
          rv_d = 1'b1;  ra_d = base_q;  ro_d = cur_q;  state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;  cur_q <= '0;  want_q <= '0;  base_q <= '0;
      rv_q <= 1'b0;  rf_q <= 1'b0;  re_q <= 1'b0;  ra_q <= '0;  ro_q <= '0;
    end else begin
      state_q <= state_d;  cur_q <= cur_d;  want_q <= want_d;  base_q <= base_d;
      rv_q <= rv_d;  rf_q <= rf_d;  re_q <= re_d;  ra_q <= ra_d;  ro_q <= ro_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = rv_q;
  assign rsp_fail  = rf_q;
  assign rsp_err   = re_q;
  assign rsp_addr  = ra_q;
  assign rsp_order = ro_q;

  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> $onehot0({rsp_fail, rsp_err}));
  assert_aligned_grant_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_valid && !rsp_fail && !rsp_err) |->
      ((rsp_addr & ((N'(1) << rsp_order) - N'(1))) == '0));
  assert_idle_on_reply_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> !busy);
  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !req_valid) |=> !rsp_valid);
  assert_search_window_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_SEARCH || state_q == ST_SPLIT) |-> (want_q <= cur_q && cur_q <= TOP));
endmodule

// File: tb/buddy_alloc_bench.sv
`timescale 1ns/1ps
module buddy_alloc_bench;
  localparam int N  = 10;
  localparam int OW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_free;
  logic [N:0]    req_size;
  logic [N-1:0]  req_addr;
  logic [OW-1:0] req_order;
  logic          busy, rsp_valid, rsp_fail, rsp_err;
  logic [N-1:0]  rsp_addr;
  logic [OW-1:0] rsp_order;

  always #2 clk = ~clk;

  buddy_alloc #(.N(N)) u_buddy_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
    .req_size(req_size), .req_addr(req_addr), .req_order(req_order),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_err(rsp_err),
    .rsp_addr(rsp_addr), .rsp_order(rsp_order)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // behavioural model: free holes per order, granted blocks by address
  int fl [N+1][$];
  int amap [int];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit in_list(int o, int a);
    foreach (fl[o][i]) if (fl[o][i] == a) return 1;
    return 0;
  endfunction

  function automatic void drop(int o, int a);
    for (int i = 0; i < fl[o].size(); i++) begin
      if (fl[o][i] == a) begin
        fl[o].delete(i);
        return;
      end
    end
  endfunction

  task automatic m_alloc(int size, output bit fail, output int a, output int o, output int lat);
    int want, f, mi;
    fail = 0; a = 0; o = 0;
    if (size < 1 || size > (1 << N)) begin
      fail = 1; lat = 0; return;
    end
    want = 0;
    while ((1 << want) < size) want++;
    f = want;
    while (f <= N && fl[f].size() == 0) f++;
    if (f > N) begin
      fail = 1; lat = N - want + 1; return;
    end
    mi = 0;
    foreach (fl[f][i]) if (fl[f][i] < fl[f][mi]) mi = i;
    a = fl[f][mi];
    fl[f].delete(mi);
    for (int k = f - 1; k >= want; k--) fl[k].push_back(a + (1 << k));
    amap[a] = want;
    o = want;
    lat = 2 * (f - want) + 1;
  endtask

  task automatic m_free(int a, int o, output bit err, output int ra, output int ro, output int lat);
    int m;
    err = 0; ra = 0; ro = 0;
    if (o > N || (a & ((1 << o) - 1)) != 0 || !amap.exists(a) || amap[a] != o) begin
      err = 1; lat = 0; return;
    end
    amap.delete(a);
    m = 0;
    while (o < N && in_list(o, a ^ (1 << o))) begin
      drop(o, a ^ (1 << o));
      a = a & ~(1 << o);
      o++;
      m++;
    end
    fl[o].push_back(a);
    ra = a; ro = o; lat = m + 1;
  endtask

  // issue one request, compare cycle by cycle against the model
  task automatic do_req(bit is_free, int size, int a, int o, string tag, bit poke);
    bit ef, ee;
    int ea, eo, lat, n;
    if (is_free) begin
      m_free(a, o, ee, ea, eo, lat); ef = 0;
    end else begin
      m_alloc(size, ef, ea, eo, lat); ee = 0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_free = is_free;
    req_size = (N+1)'(size); req_addr = N'(a); req_order = OW'(o);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n <= lat + 2) begin
      chk(busy == 1'b1 && rsp_valid == 1'b0, "R8", "busy while working", busy, 1);
      if (poke) begin
        req_valid = 1'b1; req_free = 1'b1; req_addr = '0; req_order = '0; req_size = '0;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(rsp_valid, "R8", "one response", rsp_valid, 1);
    chk(n == lat, "R9", "response latency", n, lat);
    chk(!busy, "R8", "idle on response", busy, 0);
    chk(rsp_fail == ef, tag, "fail flag", rsp_fail, ef);
    chk(rsp_err == ee, tag, "error flag", rsp_err, ee);
    if (!ef && !ee) begin
      chk(int'(rsp_addr) == ea, tag, "address", rsp_addr, ea);
      chk(int'(rsp_order) == eo, tag, "order", rsp_order, eo);
    end
    @(negedge clk);
    chk(!rsp_valid, "R8", "single-cycle pulse", rsp_valid, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int pick, cnt, ka, ko;
    fl[N].push_back(0);
    rst_n = 1'b0; req_valid = 1'b0; req_free = 1'b0;
    req_size = '0; req_addr = '0; req_order = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!rsp_valid, "R1", "no response after reset", rsp_valid, 0);

    // whole region is one block
    do_req(0, 1024, 0, 0, "R1", 0);
    do_req(0, 1, 0, 0, "R6", 0);
    do_req(1, 0, 0, 10, "R5", 0);

    // rounding and splitting
    do_req(0, 70, 0, 0, "R2", 0);
    do_req(0, 35, 0, 0, "R2", 0);
    do_req(0, 80, 0, 0, "R4", 0);
    do_req(0, 64, 0, 0, "R4", 0);
    do_req(0, 128, 0, 0, "R4", 0);
    do_req(0, 512, 0, 0, "R4", 0);
    do_req(0, 1, 0, 0, "R6", 0);
    do_req(1, 0, 192, 6, "R5", 0);
    do_req(1, 0, 384, 7, "R5", 0);
    do_req(1, 0, 512, 9, "R5", 0);
    do_req(0, 60, 0, 0, "R3", 0);

    // releases with recursive merging, stray requests while busy
    do_req(1, 0, 0, 7, "R5", 0);
    do_req(1, 0, 128, 6, "R5", 1);
    do_req(1, 0, 192, 6, "R5", 1);
    do_req(1, 0, 256, 7, "R5", 1);

    // rejected releases and sizes
    do_req(1, 0, 0, 10, "R7", 0);
    do_req(1, 0, 3, 1, "R7", 0);
    do_req(1, 0, 0, 11, "R7", 0);
    do_req(0, 0, 0, 0, "R6", 0);
    do_req(0, 1025, 0, 0, "R6", 0);
    do_req(0, 1024, 0, 0, "R7", 0);
    do_req(1, 0, 0, 10, "R5", 0);

    // mixed traffic
    for (int t = 0; t < 400; t++) begin
      if ($urandom_range(99) < 55 || amap.size() == 0) begin
        if ($urandom_range(19) == 0) do_req(0, $urandom_range(1100), 0, 0, "R6", 0);
        else do_req(0, $urandom_range(200, 1), 0, 0, "R3", t % 7 == 0);
      end else if ($urandom_range(9) == 0) begin
        do_req(1, 0, $urandom_range(1023), $urandom_range(11), "R7", 0);
      end else begin
        pick = $urandom_range(amap.size() - 1);
        cnt = 0; ka = 0; ko = 0;
        foreach (amap[key]) begin
          if (cnt == pick) begin ka = key; ko = amap[key]; end
          cnt++;
        end
        do_req(1, 0, ka, ko, "R5", t % 5 == 0);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule